// File: doc/BRIEF.md
# Dual-View GPIO Register File

This block keeps the output-data and output-enable state of a set of digital I/O pins and brings the synchronized pin inputs back to software. A byte-wide register bus reaches that state through two views of one storage. The first view gives each pin a byte of its own. The second view packs eight pins into one byte, with separate groups of bank bytes for inputs, output data and output enables. A write through either view changes the state that the other view reads. Pin inputs pass through a two-flop synchronizer before any read sees them.

One pin can carry a clock in place of its data bit. A 2-bit selector, taken from the output-data bits of two other pins, chooses between the GPIO value, a fast clock input and a slow clock input. The selector goes through a register before it steers the output mux, so a bus write cannot switch the mux part way through a cycle. A fixed identification area returns a model code and a revision byte. Reads have a latency of one cycle. Serial front ends and pin routing sit outside this block.

Top module: `gpio_dual_view`

## Requirements
- R1: After reset every output-enable bit and every output-data bit is 0, so `pin_oe` and `pin_out` are all zero, and a per-pin read returns 0x00 while the inputs are low.
- R2: A write to per-pin offset N (0x0000 plus N, for N below the pin count) loads data bit 0 into the output enable of pin N and data bit 1 into its output data. Bits 7:3 of the written byte are ignored. A read of the offset returns the output enable in bit 0, the output data in bit 1, the synchronized input in bit 2, and zero in bits 7:3.
- R3: A pin input passes two flops before reads see it. A read registered at the second rising edge after an input change still returns the old value. A read one cycle later returns the new value.
- R4: A write to output-data bank byte B (0x0110 plus B) sets the output data of pins 8B to 8B+7 from data bits 0 to 7, and all eight pins change on the same clock edge.
- R5: A write to output-enable bank byte B (0x0120 plus B) sets the output enables of pins 8B to 8B+7 from data bits 0 to 7 on one clock edge.
- R6: A read of input bank byte B (0x0100 plus B) returns the synchronized input of pin 8B+i in bit i.
- R7: Both views share one storage. State written per pin reads back at bank B = N/8, bit N mod 8, and state written per bank reads back through the per-pin bytes.
- R8: Offsets 0x0130, 0x0131 and 0x0132 read 0x41, 0x00 and the revision parameter. They ignore writes.
- R9: Writes to input bank bytes, to the identification bytes and to any unmapped offset change no output data and no output enable. Reads of unmapped offsets return 0x00.
- R10: The clock-capable pin (default 40) drives a 2-bit select whose high bit is the output data of pin 87 and whose low bit is the output data of pin 88. Select 00 gives its own output-data bit, 01 gives `clk_fast`, and 10 or 11 give `clk_slow`. The select is registered, so a change shows on the pin one clock after the write lands.
- R11: `bus_rdata` loads on the rising edge at which `bus_rd` is high and holds its value on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and synchronizer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, data returned next cycle |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | NPINS | Raw pin inputs, asynchronous |
| pin_out | output | NPINS | Pin output data, with the clock override applied on one pin |
| pin_oe | output | NPINS | Pin output enables |
| clk_fast | input | 1 | Faster override clock |
| clk_slow | input | 1 | Slower override clock |

## Verification
The hardest case to reach from the ports is the window in which a select write has landed in storage but the registered select has not yet moved. For that one cycle the clock pin must still show its GPIO bit. The bench samples the pin on the falling edge right after the write, and again one cycle later, where the pin must follow the chosen clock. The synchronizer edge is handled the same way: the input changes at a falling edge and the read is placed so that its registering edge falls exactly between the two flops. Bank and per-pin views are cross-read after each kind of write, so a mapping slip in either direction shows up as a mismatch.

// File: rtl/gpio_dv_pkg.sv
package gpio_dv_pkg;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_PIN,
    RG_BIN,
    RG_BOD,
    RG_BOE,
    RG_ID
  } region_e;

  localparam logic [15:0] PIN_END  = 16'h0080;
  localparam logic [11:0] BIN_PAGE = 12'h010;
  localparam logic [11:0] BOD_PAGE = 12'h011;
  localparam logic [11:0] BOE_PAGE = 12'h012;
  localparam logic [15:0] ID_BASE  = 16'h0130;
  localparam logic [7:0]  ID_MODEL_HI = 8'h41;
  localparam logic [7:0]  ID_MODEL_LO = 8'h00;

  // Map a byte offset to the region it belongs to.
  function automatic region_e decode(input logic [15:0] a, input int npins);
    logic [31:0] ax;
    logic [31:0] bx;
    logic [31:0] nb;
    ax = {16'd0, a};
    bx = {28'd0, a[3:0]};
    nb = 32'(npins / 8);
    if (a < PIN_END) return (ax < 32'(npins)) ? RG_PIN : RG_NONE;
    if (a[15:4] == BIN_PAGE) return (bx < nb) ? RG_BIN : RG_NONE;
    if (a[15:4] == BOD_PAGE) return (bx < nb) ? RG_BOD : RG_NONE;
    if (a[15:4] == BOE_PAGE) return (bx < nb) ? RG_BOE : RG_NONE;
    if (a >= ID_BASE && a <= ID_BASE + 16'd2) return RG_ID;
    return RG_NONE;
  endfunction

  function automatic logic [7:0] id_byte(input logic [1:0] off, input logic [7:0] rev);
    case (off)
      2'd0:    return ID_MODEL_HI;
      2'd1:    return ID_MODEL_LO;
      2'd2:    return rev;
      default: return 8'h00;
    endcase
  endfunction

  // Pack a per-pin view byte.
  function automatic logic [7:0] pin_byte(input logic in_b, input logic od_b, input logic oe_b);
    return {5'b00000, in_b, od_b, oe_b};
  endfunction

endpackage

// File: rtl/gpio_dv_sync.sv
module gpio_dv_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_dv_store.sv
module gpio_dv_store #(
  parameter int NPINS  = 128,
  parameter int PIDX_W = 7,
  parameter int BIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_we,
  input  logic [PIDX_W-1:0] pin_idx,
  input  logic              bod_we,
  input  logic              boe_we,
  input  logic [BIDX_W-1:0] bank_idx,
  input  logic [7:0]        wdata,
  output logic [NPINS-1:0]  od,
  output logic [NPINS-1:0]  oe
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    localparam int BK = g / 8;
    localparam int BT = g % 8;
    logic od_q;
    logic oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        od_q <= 1'b0;
        oe_q <= 1'b0;
      end else begin
        if (pin_we && pin_idx == PIDX_W'(g)) begin
          od_q <= wdata[1];
          oe_q <= wdata[0];
        end
        if (bod_we && bank_idx == BIDX_W'(BK)) od_q <= wdata[BT];
        if (boe_we && bank_idx == BIDX_W'(BK)) oe_q <= wdata[BT];
      end
    end

    assign od[g] = od_q;
    assign oe[g] = oe_q;
  end
endmodule

// File: rtl/gpio_dv_clksel.sv
module gpio_dv_clksel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_src,
  input  logic       gpio_bit,
  input  logic       clk_fast,
  input  logic       clk_slow,
  output logic       pin_drive
);
  logic [1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 2'b00;
    else        sel_q <= sel_src;
  end

  always_comb begin
    case (sel_q)
      2'b00:   pin_drive = gpio_bit;
      2'b01:   pin_drive = clk_fast;
      default: pin_drive = clk_slow;
    endcase
  end
endmodule

// File: rtl/gpio_dual_view.sv
module gpio_dual_view #(
  parameter int          NPINS   = 128,
  parameter logic [7:0]  REV     = 8'h03,
  parameter int          CLK_PIN = 40,
  parameter int          SEL_HI  = 87,
  parameter int          SEL_LO  = 88
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  input  logic             clk_fast,
  input  logic             clk_slow
);
  import gpio_dv_pkg::*;

  localparam int NBANK  = NPINS / 8;
  localparam int PIDX_W = $clog2(NPINS);
  localparam int BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  region_e           rg;
  logic [PIDX_W-1:0] pin_idx;
  logic [BIDX_W-1:0] bank_idx;
  logic [PIDX_W-1:0] bank_base;
  logic              wr_pin_hit;
  logic              wr_bank_od;
  logic              wr_bank_oe;
  logic              wr_ignored;
  logic [NPINS-1:0]  in_sync;
  logic [NPINS-1:0]  od;
  logic [NPINS-1:0]  oe;
  logic [7:0]        rd_next;
  logic              ovr_drive;

  assign rg         = decode(bus_addr, NPINS);
  assign pin_idx    = bus_addr[PIDX_W-1:0];
  assign bank_idx   = bus_addr[BIDX_W-1:0];
  assign bank_base  = PIDX_W'({bank_idx, 3'b000});
  assign wr_pin_hit = bus_wr && (rg == RG_PIN);
  assign wr_bank_od = bus_wr && (rg == RG_BOD);
  assign wr_bank_oe = bus_wr && (rg == RG_BOE);
  assign wr_ignored = bus_wr && !(wr_pin_hit || wr_bank_od || wr_bank_oe);

  gpio_dv_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (in_sync)
  );

  gpio_dv_store #(.NPINS(NPINS), .PIDX_W(PIDX_W), .BIDX_W(BIDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_we   (wr_pin_hit),
    .pin_idx  (pin_idx),
    .bod_we   (wr_bank_od),
    .boe_we   (wr_bank_oe),
    .bank_idx (bank_idx),
    .wdata    (bus_wdata),
    .od       (od),
    .oe       (oe)
  );

  gpio_dv_clksel u_clksel (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_src   ({od[SEL_HI], od[SEL_LO]}),
    .gpio_bit  (od[CLK_PIN]),
    .clk_fast  (clk_fast),
    .clk_slow  (clk_slow),
    .pin_drive (ovr_drive)
  );

  always_comb begin
    case (rg)
      RG_PIN:  rd_next = pin_byte(in_sync[pin_idx], od[pin_idx], oe[pin_idx]);
      RG_BIN:  rd_next = in_sync[bank_base +: 8];
      RG_BOD:  rd_next = od[bank_base +: 8];
      RG_BOE:  rd_next = oe[bank_base +: 8];
      RG_ID:   rd_next = id_byte(bus_addr[1:0], REV);
      default: rd_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  always_comb begin
    pin_out          = od;
    pin_out[CLK_PIN] = ovr_drive;
  end

  assign pin_oe = oe;
endmodule

// File: rtl/gpio_dual_view_chk.sv
module gpio_dual_view_chk #(
  parameter int NPINS   = 128,
  parameter int CLK_PIN = 40,
  parameter int SEL_HI  = 87,
  parameter int SEL_LO  = 88,
  parameter int PIDX_W  = 7,
  parameter int BIDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        bus_wdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pin_oe,
  input logic              clk_fast,
  input logic              clk_slow,
  input logic [NPINS-1:0]  od_vec,
  input logic              wr_pin_hit,
  input logic              wr_bank_od,
  input logic              wr_bank_oe,
  input logic              wr_ignored,
  input logic [PIDX_W-1:0] pin_idx,
  input logic [BIDX_W-1:0] bank_idx
);
  logic [1:0] sel_src;
  assign sel_src = {od_vec[SEL_HI], od_vec[SEL_LO]};

  // R2
  a_r2_pin_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pin_hit |=> (od_vec[$past(pin_idx)] == $past(bus_wdata[1])) &&
                   (pin_oe[$past(pin_idx)] == $past(bus_wdata[0])));

  // R4
  a_r4_bank_od: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bank_od |=> od_vec[32'($past(bank_idx)) * 8 +: 8] == $past(bus_wdata));

  // R5
  a_r5_bank_oe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bank_oe |=> pin_oe[32'($past(bank_idx)) * 8 +: 8] == $past(bus_wdata));

  // R9
  a_r9_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ignored |=> $stable(od_vec) && $stable(pin_oe));

  // R10
  a_r10_gpio_path: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_src) == 2'b00) |-> pin_out[CLK_PIN] == od_vec[CLK_PIN]);

  a_r10_fast_path: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_src) == 2'b01) |-> pin_out[CLK_PIN] == clk_fast);

  a_r10_slow_path: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_src[1]) == 1'b1) |-> pin_out[CLK_PIN] == clk_slow);

  // R11
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind gpio_dual_view gpio_dual_view_chk #(
  .NPINS(NPINS), .CLK_PIN(CLK_PIN), .SEL_HI(SEL_HI), .SEL_LO(SEL_LO),
  .PIDX_W(PIDX_W), .BIDX_W(BIDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_rd     (bus_rd),
  .bus_rdata  (bus_rdata),
  .bus_wdata  (bus_wdata),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .clk_fast   (clk_fast),
  .clk_slow   (clk_slow),
  .od_vec     (od),
  .wr_pin_hit (wr_pin_hit),
  .wr_bank_od (wr_bank_od),
  .wr_bank_oe (wr_bank_oe),
  .wr_ignored (wr_ignored),
  .pin_idx    (pin_idx),
  .bank_idx   (bank_idx)
);

// File: tb/tb_gpio_dual_view.sv
module tb_gpio_dual_view;
  localparam int         NP    = 128;
  localparam logic [7:0] REV_E = 8'h03;
  localparam int         CKP   = 40;
  localparam int         SHI   = 87;
  localparam int         SLO   = 88;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;
  logic          clk_fast = 1'b0;
  logic          clk_slow = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [NP-1:0] m_od = '0;
  logic [NP-1:0] m_oe = '0;
  logic [NP-1:0] m_in = '0;

  logic [7:0] qv[$];
  string      qt[$];
  logic       rd_seen = 1'b0;

  gpio_dual_view dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .clk_fast(clk_fast), .clk_slow(clk_slow)
  );

  always #5 clk = ~clk;
  initial begin #1; forever #35 clk_fast = ~clk_fast; end
  initial begin #2; forever #40 clk_slow = ~clk_slow; end

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected read byte, built from the requirement text.
  function automatic logic [7:0] exp_read(input logic [15:0] a);
    logic [7:0] r;
    int b;
    r = 8'h00;
    b = int'(a[3:0]);
    if (a < 16'h0080) r = {5'd0, m_in[a[6:0]], m_od[a[6:0]], m_oe[a[6:0]]};
    else if (a >= 16'h0100 && a < 16'h0110) for (int i = 0; i < 8; i++) r[i] = m_in[b*8+i];
    else if (a >= 16'h0110 && a < 16'h0120) for (int i = 0; i < 8; i++) r[i] = m_od[b*8+i];
    else if (a >= 16'h0120 && a < 16'h0130) for (int i = 0; i < 8; i++) r[i] = m_oe[b*8+i];
    else if (a == 16'h0130) r = 8'h41;
    else if (a == 16'h0132) r = REV_E;
    return r;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a < 16'h0080) begin
      m_oe[a[6:0]] = d[0];
      m_od[a[6:0]] = d[1];
    end else if (a >= 16'h0110 && a < 16'h0120) begin
      for (int i = 0; i < 8; i++) m_od[int'(a[3:0])*8+i] = d[i];
    end else if (a >= 16'h0120 && a < 16'h0130) begin
      for (int i = 0; i < 8; i++) m_oe[int'(a[3:0])*8+i] = d[i];
    end
  endtask

  // Driver: issue a read and push what it must return.
  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    qv.push_back(exp);
    qt.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_m(input logic [15:0] a, input string tag);
    rd(a, exp_read(a), tag);
  endtask

  // Monitor: compare each returned byte against the queue.
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (qv.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11: read data %h with empty scoreboard, expected none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = qv.pop_front();
        t = qt.pop_front();
        chk(t, NP'(bus_rdata), NP'(e));
      end
    end
  end

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [NP-1:0] snap_o;
    logic [NP-1:0] snap_e;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", pin_oe, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe after reset", pin_oe, '0);
    chk("R1 out after reset", pin_out, '0);
    rd_m(16'h0005, "R1 per-pin read");
    rd_m(16'h0112, "R1 bank od read");

    // R2 per-pin write, reserved bits dropped
    wr(16'h0026, 8'hFF);
    chk("R2 oe pin 0x26", NP'(pin_oe[38]), NP'(1'b1));
    chk("R2 out pin 0x26", NP'(pin_out[38]), NP'(1'b1));
    rd(16'h0026, 8'h03, "R2 per-pin readback");
    wr(16'h0010, 8'hFA);
    chk("R2 od only pin 0x10", {pin_oe[16], pin_out[16]}, NP'(2'b01));
    rd(16'h0010, 8'h02, "R2 reserved bits read zero");

    // R3 synchronizer latency
    @(negedge clk);
    pin_in[38] = 1'b1;
    rd(16'h0026, 8'h03, "R3 input not yet through two flops");
    rd(16'h0026, 8'h07, "R3 input after two flops");
    m_in[38] = 1'b1;

    // R4/R5 bank writes, all eight pins at once
    wr(16'h0112, 8'hA5);
    chk("R4 bank2 od slice", NP'(pin_out[23:16]), NP'(8'hA5));
    wr(16'h0122, 8'h3C);
    chk("R5 bank2 oe slice", NP'(pin_oe[23:16]), NP'(8'h3C));
    wr(16'h011F, 8'h81);
    chk("R4 bank15 od slice", NP'(pin_out[127:120]), NP'(8'h81));

    // R7 cross view
    rd_m(16'h0010, "R7 pin16 via per-pin after bank");
    rd_m(16'h0012, "R7 pin18 via per-pin after bank");
    rd_m(16'h0015, "R7 pin21 via per-pin after bank");
    rd_m(16'h0114, "R7 bank4 od holds per-pin writes");
    rd_m(16'h0124, "R7 bank4 oe holds per-pin writes");
    wr(16'h0013, 8'h00);
    rd_m(16'h0112, "R7 bank2 od after per-pin clear");
    rd_m(16'h0122, "R7 bank2 oe after per-pin clear");

    // R6 bank input
    @(negedge clk);
    pin_in[7:0] = 8'h5A;
    pin_in[127] = 1'b1;
    repeat (3) @(negedge clk);
    m_in[7:0] = 8'h5A;
    m_in[127] = 1'b1;
    rd_m(16'h0100, "R6 bank0 input");
    rd_m(16'h0104, "R6 bank4 input");
    rd_m(16'h010F, "R6 bank15 input");

    // R8 identification
    rd(16'h0130, 8'h41, "R8 model high");
    rd(16'h0131, 8'h00, "R8 model low");
    rd(16'h0132, REV_E, "R8 revision");

    // R9 ignored writes
    snap_o = pin_out;
    snap_e = pin_oe;
    wr(16'h0101, 8'hFF);
    wr(16'h0130, 8'hFF);
    wr(16'h0200, 8'hFF);
    wr(16'h00A0, 8'hFF);
    chk("R9 outputs unchanged", pin_out, snap_o);
    chk("R9 enables unchanged", pin_oe, snap_e);
    rd(16'h0130, 8'h41, "R8 ID ignores write");
    rd(16'h0200, 8'h00, "R9 unmapped read");
    rd(16'h00A0, 8'h00, "R9 unmapped low read");
    rd(16'h0133, 8'h00, "R9 past ID read");
    rd_m(16'h0101, "R9 bank input ignores write");

    // R10 clock override
    wr(16'h0028, 8'h03);
    chk("R10 select 00 gives GPIO", NP'(pin_out[CKP]), NP'(1'b1));
    wr(16'h0058, 8'h02);
    chk("R10 select not yet registered", NP'(pin_out[CKP]), NP'(1'b1));
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      chk("R10 select 01 fast clock", NP'(pin_out[CKP]), NP'(clk_fast));
      #17;
    end
    wr(16'h0057, 8'h02);
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      chk("R10 select 11 slow clock", NP'(pin_out[CKP]), NP'(clk_slow));
      #19;
    end
    wr(16'h0058, 8'h00);
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      chk("R10 select 10 slow clock", NP'(pin_out[CKP]), NP'(clk_slow));
      #19;
    end
    wr(16'h0057, 8'h00);
    @(negedge clk);
    chk("R10 back to GPIO", NP'(pin_out[CKP]), NP'(1'b1));
    chk("R10 oe untouched by override", NP'(pin_oe[CKP]), NP'(1'b1));

    // R11 read data holds without a read strobe
    rd(16'h0026, 8'h07, "R11 read before hold");
    wr(16'h0026, 8'h00);
    repeat (3) @(negedge clk);
    chk("R11 rdata holds", NP'(bus_rdata), NP'(8'h07));

    repeat (3) @(negedge clk);
    if (qv.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R11: %0d reads unanswered, expected 0", qv.size());
    end
    summary();
  end
endmodule